// File: doc/BRIEF.md
# Modem Status Tracker with Loopback

This block keeps the eight-bit modem status value of a serial port. The upper four bits show the present state of the four handshake inputs: clear-to-send, data-set-ready, ring indicate and carrier detect. The lower four bits are sticky change flags, one for each input. Any set change flag raises an interrupt request.

In normal operation the status inputs come from the external pins through a two-flop synchronizer. When loopback is enabled, the pins are ignored and the four modem control outputs are fed back onto the status inputs. This lets software exercise the status logic without a cable attached. A read strobe presents the current value to the reader. The change flags clear once the strobe cycle ends. An event that arrives in the same cycle as a read is kept.

Top module: `modem_stat_loop`

## Requirements
- R1: After reset, `stat_o` is 0x00 and `irq_o` is 0.
- R2: With `loop_en_i` high, the status bits take these values one clock after a change on `mctl_i`. Bit 4 (clear-to-send) follows `mctl_i[1]`. Bit 5 (data-set-ready) follows `mctl_i[0]`. Bit 6 (ring) follows `mctl_i[2]`. Bit 7 (carrier) follows `mctl_i[3]`.
- R3: The change flags for clear-to-send (bit 0), data-set-ready (bit 1) and carrier (bit 3) set on every change of their status bit, rising or falling.
- R4: The ring change flag (bit 2) sets only when the ring status bit falls from 1 to 0. A rise does not set it.
- R5: During the cycle in which `rd_stb_i` is high, `stat_o` shows the current value. After that clock edge, the change flags are 0 unless a new event occurred.
- R6: A set change flag stays set until a read.
- R7: `irq_o` is 1 exactly when any of bits 3:0 of `stat_o` is 1.
- R8: If a status bit changes in the same cycle as a read, its change flag is set after the edge.
- R9: With `loop_en_i` low, the status bits follow the external lines three clocks after a change (two synchronizer stages and the status register). `mctl_i` then has no effect on `stat_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mctl_i | input | 4 | Modem control outputs: [0] terminal ready, [1] request to send, [2] aux 1, [3] aux 2 |
| loop_en_i | input | 1 | Loopback enable |
| ext_cts_i | input | 1 | External clear-to-send line |
| ext_dsr_i | input | 1 | External data-set-ready line |
| ext_ri_i | input | 1 | External ring indicate line |
| ext_dcd_i | input | 1 | External carrier detect line |
| rd_stb_i | input | 1 | Status read strobe |
| stat_o | output | 8 | Status value: [7:4] lines, [3:0] change flags |
| irq_o | output | 1 | Modem status interrupt request |

## Verification
If the stored line copy goes wrong, `stat_o[7:4]` is wrong one clock after the next change. It also shows up as a change flag that is missing or spurious on that same edge. A change flag that is stuck or lost shows up on `irq_o` at the same time. It persists until the next read, so a check made just before a read catches it. A wrong synchronizer depth moves the first visible change on an external line away from the third edge. The bench samples both the second and the third edge.

// File: rtl/msl_pkg.sv
package msl_pkg;
  // line vector order, shared by status bits [7:4] and change flags [3:0]
  localparam int LINES = 4;
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;
  // modem control bit positions
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_AUX1 = 2;
  localparam int C_AUX2 = 3;
  typedef logic [LINES-1:0] line_vec_t;
endpackage

// File: rtl/msl_sync.sv
module msl_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/msl_src_mux.sv
module msl_src_mux
  import msl_pkg::*;
(
  input  logic      loop_en_i,
  input  line_vec_t mctl_i,
  input  line_vec_t ext_i,
  output line_vec_t src_o
);
  line_vec_t looped;

  always_comb begin
    looped        = '0;
    looped[L_CTS] = mctl_i[C_RTS];
    looped[L_DSR] = mctl_i[C_DTR];
    looped[L_RI]  = mctl_i[C_AUX1];
    looped[L_DCD] = mctl_i[C_AUX2];
  end

  assign src_o = loop_en_i ? looped : ext_i;
endmodule

// File: rtl/msl_status_reg.sv
module msl_status_reg
  import msl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t src_i,
  input  logic      rd_i,
  output line_vec_t line_o,
  output line_vec_t delta_o
);
  line_vec_t line_q, delta_q, event_v;

  always_comb begin
    event_v        = src_i ^ line_q;
    event_v[L_RI]  = line_q[L_RI] & ~src_i[L_RI];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      delta_q <= '0;
    end else begin
      line_q  <= src_i;
      delta_q <= (rd_i ? '0 : delta_q) | event_v;
    end
  end

  assign line_o  = line_q;
  assign delta_o = delta_q;

  // R3
  cts_change_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i[L_CTS] != line_q[L_CTS]) |=> delta_q[L_CTS]);

  // R4
  ri_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta_q[L_RI]) |-> ($past(line_q[L_RI]) && !line_q[L_RI]));

  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && (src_i == line_q)) |=> (delta_q == '0));

  // R6
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  // R8
  read_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && (src_i[L_DCD] != line_q[L_DCD])) |=> delta_q[L_DCD]);
endmodule

// File: rtl/modem_stat_loop.sv
module modem_stat_loop
  import msl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mctl_i,
  input  logic       loop_en_i,
  input  logic       ext_cts_i,
  input  logic       ext_dsr_i,
  input  logic       ext_ri_i,
  input  logic       ext_dcd_i,
  input  logic       rd_stb_i,
  output logic [7:0] stat_o,
  output logic       irq_o
);
  line_vec_t ext_raw, ext_sync, src, line_v, delta_v;

  always_comb begin
    ext_raw        = '0;
    ext_raw[L_CTS] = ext_cts_i;
    ext_raw[L_DSR] = ext_dsr_i;
    ext_raw[L_RI]  = ext_ri_i;
    ext_raw[L_DCD] = ext_dcd_i;
  end

  msl_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ext_raw), .q_o(ext_sync));

  msl_src_mux u_mux (
    .loop_en_i(loop_en_i), .mctl_i(mctl_i), .ext_i(ext_sync), .src_o(src));

  msl_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .src_i(src), .rd_i(rd_stb_i),
    .line_o(line_v), .delta_o(delta_v));

  assign stat_o = {line_v, delta_v};
  assign irq_o  = |delta_v;

  // R2
  loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en_i && $past(loop_en_i)) |->
      (stat_o[7:4] == {$past(mctl_i[3]), $past(mctl_i[2]), $past(mctl_i[0]), $past(mctl_i[1])}));

  // R7
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (stat_o[3:0] != 4'h0));
endmodule

// File: tb/modem_stat_loop_test.sv
module modem_stat_loop_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mctl_i = '0;
  logic       loop_en_i = 1'b0;
  logic       ext_cts_i = 1'b0, ext_dsr_i = 1'b0, ext_ri_i = 1'b0, ext_dcd_i = 1'b0;
  logic       rd_stb_i = 1'b0;
  logic [7:0] stat_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  modem_stat_loop uut (
    .clk(clk), .rst_n(rst_n), .mctl_i(mctl_i), .loop_en_i(loop_en_i),
    .ext_cts_i(ext_cts_i), .ext_dsr_i(ext_dsr_i), .ext_ri_i(ext_ri_i),
    .ext_dcd_i(ext_dcd_i), .rd_stb_i(rd_stb_i), .stat_o(stat_o), .irq_o(irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // driver side: push expected status; irq expectation from R7
  task automatic expect_stat(input logic [7:0] v, input string tag);
    exp_q.push_back({|v[3:0], v});
    tag_q.push_back(tag);
    #2;
  endtask

  // monitor: compare queued expectations away from the clock edge
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      #1;
      begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({irq_o, stat_o} !== e) begin
          errors++;
          $display("FAIL %s: actual irq=%0b stat=%02h expected irq=%0b stat=%02h",
                   t, irq_o, stat_o, e[8], e[7:0]);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    expect_stat(8'h00, "R1 reset");
    rst_n = 1'b1;
    loop_en_i = 1'b1;
    cyc(2);
    expect_stat(8'h00, "R1 idle after reset");

    mctl_i = 4'b0010;                  // request to send
    cyc(1);
    expect_stat(8'h11, "R2 R3 R7 rts to cts");
    cyc(3);
    expect_stat(8'h11, "R6 flag held");

    rd_stb_i = 1'b1;
    expect_stat(8'h11, "R5 value during read");
    cyc(1);
    rd_stb_i = 1'b0;
    expect_stat(8'h10, "R5 cleared after read");

    mctl_i = 4'b1111;
    cyc(1);
    expect_stat(8'hFA, "R2 R4 ring rise no flag");
    rd_stb_i = 1'b1; cyc(1); rd_stb_i = 1'b0;
    expect_stat(8'hF0, "R5 clear");

    mctl_i = 4'b1011;                  // aux1 low, ring falls
    cyc(1);
    expect_stat(8'hB4, "R4 ring fall flag");
    rd_stb_i = 1'b1; cyc(1); rd_stb_i = 1'b0;
    expect_stat(8'hB0, "R5 clear ring");

    mctl_i = 4'b0011;                  // aux2 low, carrier falls
    cyc(1);
    expect_stat(8'h38, "R3 carrier fall");
    rd_stb_i = 1'b1;
    mctl_i = 4'b0001;                  // rts low in read cycle
    expect_stat(8'h38, "R5 read value");
    cyc(1);
    rd_stb_i = 1'b0;
    expect_stat(8'h21, "R8 change during read kept");
    cyc(5);
    expect_stat(8'h21, "R6 flag sticky");

    loop_en_i = 1'b0;
    cyc(1);
    expect_stat(8'h03, "R9 switch to external lines");
    rd_stb_i = 1'b1; cyc(1); rd_stb_i = 1'b0;
    expect_stat(8'h00, "R5 clear ext");

    ext_cts_i = 1'b1;
    cyc(2);
    expect_stat(8'h00, "R9 sync latency not yet");
    cyc(1);
    expect_stat(8'h11, "R9 ext cts after three edges");

    mctl_i = 4'b1111;
    cyc(4);
    expect_stat(8'h11, "R9 mctl ignored outside loopback");
    rd_stb_i = 1'b1; cyc(1); rd_stb_i = 1'b0;
    expect_stat(8'h10, "R5 clear ext cts");

    ext_ri_i = 1'b1;
    cyc(3);
    expect_stat(8'h50, "R4 ext ring rise no flag");
    ext_ri_i = 1'b0;
    cyc(2);
    expect_stat(8'h50, "R9 ring fall pending sync");
    cyc(1);
    expect_stat(8'h14, "R4 ext ring fall flag");

    wait (exp_q.size() == 0);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule